// File: doc/BRIEF.md
# Key storage serial memory controller

This block links a host to an external serial SRAM on an SPI bus. It keeps one 32-bit status word and one 256-bit key in that memory. The host raises one of three command inputs for a single clock: set up the memory, store an object, or fetch an object. A target input chooses the object. Each command becomes one complete chip-select frame on the serial bus. That frame holds the instruction, the address and all the data bytes.

`ready` drops while a frame is on the bus and stays low through a guard time after the frame. It then rises again. Fetched data appears on `status_out` or `key_out`, and the output holds that value until the same object is fetched again. The serial clock is the system clock divided by the even parameter `DIV`. The bus runs in mode 0: the clock idles low, data changes on the falling edge and is sampled on the rising edge.

Top module: `keystore_spi`

## Requirements
- R1: After reset, `ready` is 1, `spi_csn` is 1, `spi_sck` is 0, and `status_out` and `key_out` are zero.
- R2: A command pulse taken while `ready` is 1 pulls `spi_csn` low on the same clock edge that drops `ready`. `spi_csn` stays low for exactly N*DIV clocks, where N is the frame length in bits. `spi_csn` then stays high for DIV clocks before `ready` returns, so a command taken at edge E raises `ready` after edge E+(N+1)*DIV.
- R3: Serial timing is mode 0. `spi_sck` is 0 whenever `spi_csn` is 1. `spi_mosi` does not change while `spi_sck` is high. Rising edges within a frame come DIV clocks apart, and each frame carries exactly N rising edges.
- R4: Set-up (`cmd_init`) sends the 16-bit frame 0x01, 0x40, most significant bit first. This writes the memory's mode register to sequential mode.
- R5: Storing with `target_key`=0 sends the 56-bit frame 0x02, address 0x0000 (16 bits), then `status_in` most significant byte first. The status word lands in memory bytes 0..3, byte 0 holding bits 31:24.
- R6: Storing with `target_key`=1 sends the 280-bit frame 0x02, address 0x0010, then `key_in` most significant byte first. The key lands in bytes 0x10..0x2F, byte 0x10 holding bits 255:248.
- R7: Fetching with `target_key`=0 sends 0x03 and address 0x0000, then samples 32 bits of `spi_miso`. The first bit sampled becomes bit 31 of `status_out`. `key_out` does not change.
- R8: Fetching with `target_key`=1 sends 0x03 and address 0x0010, then samples 256 bits into `key_out`, most significant bit first. `status_out` does not change.
- R9: Command pulses that arrive while `ready` is 0 are ignored. They do not lengthen the busy time and do not change memory contents or outputs.
- R10: When pulses arrive together, set-up wins over store, and store wins over fetch.
- R11: `status_out` and `key_out` hold their values while `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_init | input | 1 | One-cycle pulse: set up memory mode |
| cmd_write | input | 1 | One-cycle pulse: store selected object |
| cmd_read | input | 1 | One-cycle pulse: fetch selected object |
| target_key | input | 1 | 0 selects status word, 1 selects key |
| status_in | input | 32 | Status word to store |
| key_in | input | 256 | Key to store |
| ready | output | 1 | High when idle and able to take a command |
| status_out | output | 32 | Last fetched status word |
| key_out | output | 256 | Last fetched key |
| spi_sck | output | 1 | Serial clock |
| spi_csn | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to memory |
| spi_miso | input | 1 | Serial data from memory |

## Verification
The assertions check the cycle-level bus rules on every clock:
- chip select goes low together with the fall of `ready`;
- chip select is high whenever the block is idle;
- the serial clock stays low outside a frame;
- `spi_mosi` stays steady while the serial clock is high;
- the read outputs hold while idle.

Only the bench's scenarios can show the rest. It uses a behavioural serial SRAM to confirm frame contents and byte placement in memory, the order of bits in fetched data, the priority between simultaneous pulses, and that pulses arriving mid-frame have no effect.

// File: rtl/keystore_spi.sv
module keystore_spi #(
  parameter int          DIV       = 4,
  parameter int          STAT_W    = 32,
  parameter int          KEY_W     = 256,
  parameter logic [15:0] STAT_ADDR = 16'h0000,
  parameter logic [15:0] KEY_ADDR  = 16'h0010,
  parameter logic [7:0]  MODE_VAL  = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_init,
  input  logic              cmd_write,
  input  logic              cmd_read,
  input  logic              target_key,
  input  logic [STAT_W-1:0] status_in,
  input  logic [KEY_W-1:0]  key_in,
  output logic              ready,
  output logic [STAT_W-1:0] status_out,
  output logic [KEY_W-1:0]  key_out,
  output logic              spi_sck,
  output logic              spi_csn,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int HALF    = DIV / 2;
  localparam int FRAME_W = 24 + KEY_W;
  localparam int CW      = $clog2(FRAME_W + 1);
  localparam int TW      = $clog2(DIV + 1);
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;

  typedef enum logic [1:0] {IDLE, SHIFT, GAP} st_t;

  st_t                st;
  logic [TW-1:0]      tick;
  logic [CW-1:0]      nbit, bitidx;
  logic [FRAME_W-1:0] txsr, frame;
  logic [KEY_W-1:0]   rxsr, payload;
  logic [CW-1:0]      len;
  logic               is_rd, sel_k;
  logic [15:0]        addr;

  assign ready    = (st == IDLE);
  assign spi_mosi = txsr[FRAME_W-1];
  assign addr     = target_key ? KEY_ADDR : STAT_ADDR;
  assign payload  = target_key ? key_in : {status_in, {(KEY_W-STAT_W){1'b0}}};

  always_comb begin
    if (cmd_init) begin
      frame = {OP_WRSR, MODE_VAL, {(FRAME_W-16){1'b0}}};
      len   = CW'(16);
    end else if (cmd_write) begin
      frame = {OP_WRITE, addr, payload};
      len   = target_key ? CW'(24 + KEY_W) : CW'(24 + STAT_W);
    end else begin
      frame = {OP_READ, addr, {KEY_W{1'b0}}};
      len   = target_key ? CW'(24 + KEY_W) : CW'(24 + STAT_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      tick       <= '0;
      nbit       <= '0;
      bitidx     <= '0;
      txsr       <= '0;
      rxsr       <= '0;
      is_rd      <= 1'b0;
      sel_k      <= 1'b0;
      spi_sck    <= 1'b0;
      spi_csn    <= 1'b1;
      status_out <= '0;
      key_out    <= '0;
    end else begin
      case (st)
        IDLE: if (cmd_init | cmd_write | cmd_read) begin
          txsr    <= frame;
          nbit    <= len;
          bitidx  <= '0;
          is_rd   <= ~cmd_init & ~cmd_write;
          sel_k   <= target_key;
          tick    <= '0;
          spi_csn <= 1'b0;
          st      <= SHIFT;
        end
        SHIFT: if (tick == TW'(HALF - 1)) begin
          tick <= '0;
          if (!spi_sck) begin
            spi_sck <= 1'b1;
            rxsr    <= {rxsr[KEY_W-2:0], spi_miso};
          end else begin
            spi_sck <= 1'b0;
            if (bitidx == nbit - CW'(1)) begin
              spi_csn <= 1'b1;
              st      <= GAP;
              if (is_rd) begin
                if (sel_k) key_out    <= rxsr;
                else       status_out <= rxsr[STAT_W-1:0];
              end
            end else begin
              bitidx <= bitidx + CW'(1);
              txsr   <= txsr << 1;
            end
          end
        end else begin
          tick <= tick + TW'(1);
        end
        GAP: if (tick == TW'(DIV - 1)) begin
          tick <= '0;
          st   <= IDLE;
        end else begin
          tick <= tick + TW'(1);
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/keystore_spi_chk.sv
module keystore_spi_chk #(
  parameter int STAT_W = 32,
  parameter int KEY_W  = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              spi_sck,
  input logic              spi_csn,
  input logic              spi_mosi,
  input logic [STAT_W-1:0] status_out,
  input logic [KEY_W-1:0]  key_out
);

  // R2
  start_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $fell(spi_csn));

  // R2
  idle_csn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> spi_csn);

  // R3
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> !spi_sck);

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_csn && spi_sck) |-> $stable(spi_mosi));

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ($stable(status_out) && $stable(key_out)));

endmodule

bind keystore_spi keystore_spi_chk #(.STAT_W(STAT_W), .KEY_W(KEY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .spi_sck(spi_sck),
  .spi_csn(spi_csn), .spi_mosi(spi_mosi),
  .status_out(status_out), .key_out(key_out));

// File: tb/keystore_spi_test.sv
module keystore_spi_test;
  localparam int DIV = 4;

  logic clk = 0, rst_n = 0;
  logic ci = 0, cw = 0, cr = 0, tk = 0;
  logic [31:0] sin = '0;
  logic [255:0] kin = '0;
  logic rdy, sck, csn, mosi;
  logic miso = 0;
  logic [31:0] sout;
  logic [255:0] kout;

  keystore_spi #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_init(ci), .cmd_write(cw), .cmd_read(cr),
    .target_key(tk), .status_in(sin), .key_in(kin), .ready(rdy),
    .status_out(sout), .key_out(kout), .spi_sck(sck), .spi_csn(csn),
    .spi_mosi(mosi), .spi_miso(miso));

  always #5 clk = ~clk;

  int vec = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // reference timing model
  int m_rem = 0, m_cs = 0, m_len = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rem <= 0; m_cs <= 0;
    end else if (m_rem == 0 && (ci || cw || cr)) begin
      int n;
      n = ci ? 16 : (tk ? 280 : 56);
      m_len <= n;
      m_rem <= (n + 1) * DIV;
      m_cs  <= n * DIV;
    end else begin
      if (m_rem > 0) m_rem <= m_rem - 1;
      if (m_cs > 0) m_cs <= m_cs - 1;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(rdy == (m_rem == 0), "R2 ready", 256'(rdy), 256'(m_rem == 0));
    chk(csn == (m_cs == 0), "R2 csn", 256'(csn), 256'(m_cs == 0));
  end

  // behavioural serial SRAM
  logic [7:0] mem [64];
  logic [7:0] mreg = 8'h00, sh = 0, op = 0;
  logic [15:0] ad = 0;
  int bc = 0, rises = 0, cyc = 0, last_rise = 0;

  always @(posedge clk) cyc++;

  always @(negedge csn) begin bc = 0; rises = 0; end

  always @(posedge sck) if (!csn) begin
    if (rises > 0) chk(cyc - last_rise == DIV, "R3 sck period", 256'(cyc - last_rise), 256'(DIV));
    last_rise = cyc;
    rises++;
    sh = {sh[6:0], mosi};
    bc++;
    if (bc == 8) op = sh;
    else if (bc == 16 && op == 8'h01) mreg = sh;
    else if (bc == 16) ad[15:8] = sh;
    else if (bc == 24) ad[7:0] = sh;
    else if (bc > 24 && bc % 8 == 0 && op == 8'h02) mem[(int'(ad) + (bc - 32) / 8) & 63] = sh;
  end

  always @(negedge sck) if (!csn && op == 8'h03 && bc >= 24) begin
    int idx;
    idx = bc - 24;
    miso = mem[(int'(ad) + idx / 8) & 63][7 - idx % 8];
  end

  always @(posedge csn) if (rst_n && !done)
    chk(rises == m_len, "R3 rising edges per frame", 256'(rises), 256'(m_len));

  function automatic logic [31:0] mstat();
    return {mem[0], mem[1], mem[2], mem[3]};
  endfunction

  function automatic logic [255:0] mkey();
    logic [255:0] k;
    for (int i = 0; i < 32; i++) k[255 - 8*i -: 8] = mem[16 + i];
    return k;
  endfunction

  task automatic cmd(input bit i, input bit r, input bit w, input bit k);
    @(negedge clk);
    ci = i; cr = r; cw = w; tk = k;
    @(negedge clk);
    ci = 0; cr = 0; cw = 0;
    while (m_rem != 0) @(negedge clk);
    @(negedge clk);
  endtask

  localparam logic [255:0] KEY_A = 256'h01020304_aa55aa55_00ff00ff_0f0e0d0c_11121314_55aa55aa_11ee11ee_1f1e1d1c;

  initial begin
    logic [31:0] held_s;
    logic [255:0] held_k;
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(rdy && csn && !sck && sout == 0 && kout == 0, "R1 reset state",
        {sout, kout[223:0]}, 256'(0));

    cmd(1, 0, 0, 0);
    chk(mreg == 8'h40, "R4 mode register", 256'(mreg), 256'h40);

    sin = 32'hdeadbeef;
    cmd(0, 0, 1, 0);
    chk(mstat() == 32'hdeadbeef, "R5 status bytes", 256'(mstat()), 256'hdeadbeef);

    cmd(0, 1, 0, 0);
    chk(sout == 32'hdeadbeef, "R7 status_out", 256'(sout), 256'hdeadbeef);
    chk(kout == 0, "R7 key_out unchanged", kout, 256'(0));

    kin = KEY_A;
    cmd(0, 0, 1, 1);
    chk(mkey() == KEY_A, "R6 key bytes", mkey(), KEY_A);
    chk(mstat() == 32'hdeadbeef, "R6 status bytes untouched", 256'(mstat()), 256'hdeadbeef);

    cmd(0, 1, 0, 1);
    chk(kout == KEY_A, "R8 key_out", kout, KEY_A);
    chk(sout == 32'hdeadbeef, "R8 status_out unchanged", 256'(sout), 256'hdeadbeef);

    // R9: pulses during busy are ignored
    sin = 32'hcafef00d;
    @(negedge clk); cw = 1; tk = 0;
    @(negedge clk); cw = 0;
    repeat (20) @(negedge clk);
    kin = '1; tk = 1; cw = 1; ci = 1; cr = 1;
    @(negedge clk); cw = 0; ci = 0; cr = 0;
    while (m_rem != 0) @(negedge clk);
    @(negedge clk);
    chk(mstat() == 32'hcafef00d, "R9 first store done", 256'(mstat()), 256'hcafef00d);
    chk(mkey() == KEY_A, "R9 key unchanged", mkey(), KEY_A);
    chk(kout == KEY_A, "R9 key_out unchanged", kout, KEY_A);

    // R10: init wins over write and read
    mreg = 8'h00;
    sin = 32'h0badc0de;
    cmd(1, 1, 1, 0);
    chk(mreg == 8'h40, "R10 init first", 256'(mreg), 256'h40);
    chk(mstat() == 32'hcafef00d, "R10 no store with init", 256'(mstat()), 256'hcafef00d);
    // R10: write wins over read
    cmd(0, 1, 1, 0);
    chk(mstat() == 32'h0badc0de, "R10 store over fetch", 256'(mstat()), 256'h0badc0de);
    chk(sout == 32'hdeadbeef, "R10 no fetch", 256'(sout), 256'hdeadbeef);

    // R7 second pattern, poked directly
    mem[0] = 8'ha5; mem[1] = 8'h5a; mem[2] = 8'h0f; mem[3] = 8'hf0;
    cmd(0, 1, 0, 0);
    chk(sout == 32'ha55a0ff0, "R7 status_out pattern 2", 256'(sout), 256'ha55a0ff0);

    // R11: outputs hold while idle
    held_s = sout; held_k = kout;
    sin = '0; kin = '0; tk = 1;
    repeat (40) @(negedge clk);
    chk(sout == held_s && kout == held_k, "R11 hold", {sout, kout[223:0]}, {held_s, held_k[223:0]});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      done = 1;
      vec++; bad++;
      $display("FAIL watchdog act=%0d exp=0", m_rem);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule